// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 16-bit interval timer that software drives through a byte-wide register port. Software writes a reload value one byte at a time into a write-only holding latch. Reads at the same two addresses return the live counter. A control byte starts and stops counting and chooses between continuous and one-shot operation. It also selects whether a count event is a system clock cycle or a rising edge on an external count input, and it shapes and routes the timer output.

When the counter is at zero and a count event arrives, the timer underflows. On that event it reloads from the latch, so one period is the latch value plus one event. A one-shot timer then clears its own start bit. A continuous timer keeps counting. Every underflow sets a sticky interrupt flag, and an enable mask turns that flag into an active-high interrupt line. When routing is enabled, the timer output takes over one port pin and forces that pin to drive, whatever its direction bit says. The output is either a one-cycle pulse or a level that toggles.

Register map: address 0 reads counter bits [7:0] and writes latch bits [7:0]. Address 1 reads counter bits [15:8] and writes latch bits [15:8]. Address 2 is the control byte, readable and writable, with bits [7:5] reading 0. Address 3 reads the interrupt status and writes the interrupt mask.

Control bits:
- bit 0: run
- bit 1: pin routing enable
- bit 2: output form, 1 for toggle and 0 for pulse
- bit 3: one-shot when 1
- bit 4: external count source when 1

Top module: `ptimer_top`

## Requirements
- R1: After reset the counter, control byte, status byte and interrupt line are all 0, the latch holds all ones, and the pin follows `port_data_in` and `port_dir_in`.
- R2: Writes to addresses 0 and 1 change only the latch: the counter value read back at addresses 0 and 1 is unchanged, except in the one-shot high-byte case of R6.
- R3: While the run bit (control bit 0) is 0, the counter holds its value.
- R4: In continuous mode (control bit 3 = 0), an event at counter value 0 reloads the latch and counting goes on, so a period is latch+1 events.
- R5: In one-shot mode (control bit 3 = 1), the underflow reloads the latch and clears the run bit, which then reads back as 0.
- R6: In one-shot mode, a write to address 1 loads the counter with {written byte, latch low byte} and sets the run bit even when it was 0.
- R7: In pulse form (control bit 2 = 0), the timer output is high for exactly one cycle, in the cycle after the underflow edge.
- R8: In toggle form (control bit 2 = 1), the output goes high when the run bit goes from 0 to 1 and inverts on every underflow.
- R9: With control bit 1 set, `pin_oe` is 1 and `pin_out` carries the timer output. With it clear, both pin outputs pass `port_dir_in` and `port_data_in` through.
- R10: An underflow sets a sticky flag, seen as status bit 0 at address 3. A read of address 3 returns the flag and clears it, unless a new underflow arrives in the same cycle.
- R11: `irq` is high exactly while the flag is set and mask bit 0 (written at address 3) is 1. Status bit 7 mirrors `irq`.
- R12: With control bit 4 set, only rising edges of `ext_count_in` count, after a two-stage synchronizer. A level held high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after the read |
| ext_count_in | input | 1 | Asynchronous external count input |
| port_data_in | input | 1 | Normal data value for the shared pin |
| port_dir_in | input | 1 | Normal direction bit for the shared pin, 1 = drive |
| pin_out | output | 1 | Value driven on the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions check the relations that hold on every cycle. These are: reload from the latch on each underflow, a frozen counter when no event occurs, the one-shot stop, the flag and interrupt setting, the pulse following an underflow, and the toggle being forced high on start. Only the bench scenarios can show the quantities that span many cycles or depend on the register map. These include the latch+1 period measured on the pin, the exact position and width of the one-shot pulse, the pin override against the direction input, the clear-on-read of the status byte, and the fact that a long external high level counts only once.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd3;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_PIN_EN = 1;
  localparam int unsigned B_TOGGLE = 2;
  localparam int unsigned B_ONCE   = 3;
  localparam int unsigned B_EXTSRC = 4;

  typedef struct packed {
    logic ext_src;
    logic one_shot;
    logic toggle;
    logic pin_en;
  } mode_t;
endpackage

// File: rtl/ptimer_sync_edge.sv
module ptimer_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_now,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] latch_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] ZERO = '0;

  assign uf_o  = tick && (cnt_q == ZERO);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (load_now) cnt_q <= load_val;
    else if (uf_o)     cnt_q <= latch_val;
    else if (tick)     cnt_q <= cnt_q - 1'b1;
  end

  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (uf_o && !load_now) |=> (cnt_q == $past(latch_val)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_now) |=> $stable(cnt_q));
endmodule

// File: rtl/ptimer_outgen.sv
module ptimer_outgen (
  input  logic clk,
  input  logic rst,
  input  logic started,
  input  logic uf,
  input  logic toggle_sel,
  output logic out_o
);
  logic tog_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= uf;
      if (started) tog_q <= 1'b1;
      else if (uf) tog_q <= ~tog_q;
    end
  end

  assign out_o = toggle_sel ? tog_q : pulse_q;

  assert_pulse_after_uf_R7: assert property (@(posedge clk) disable iff (rst)
    uf |=> pulse_q);

  assert_start_sets_tog_R8: assert property (@(posedge clk) disable iff (rst)
    started |=> tog_q);
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              uf_i,
  output logic [BUS_W-1:0]  bus_rdata,
  output mode_t             mode_o,
  output logic              run_o,
  output logic              started_o,
  output logic              load_now_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  latch_o,
  output logic              irq_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] latch_q;
  mode_t            mode_q;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             mask_q, mask_d;
  logic             irq_q;
  logic [BUS_W-1:0] rdata_q;
  logic             wr_ctrl, wr_hi, wr_lo, wr_stat, rd_stat;

  assign wr_lo   = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_hi   = bus_wr && (bus_addr == A_CNT_HI);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign rd_stat = bus_rd && (bus_addr == A_STAT);

  assign load_now_o = wr_hi && mode_q.one_shot;
  assign load_val_o = {bus_wdata[HALF_W-1:0], latch_q[HALF_W-1:0]};

  always_comb begin
    run_d = run_q;
    if (uf_i && mode_q.one_shot) run_d = 1'b0;
    if (wr_ctrl)                 run_d = bus_wdata[B_RUN];
    if (load_now_o)              run_d = 1'b1;
  end

  always_comb begin
    flag_d = flag_q;
    if (rd_stat) flag_d = 1'b0;
    if (uf_i)    flag_d = 1'b1;
    mask_d = wr_stat ? bus_wdata[0] : mask_q;
  end

  assign started_o = run_d && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      mode_q  <= '0;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
      mask_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_lo) latch_q[HALF_W-1:0]     <= bus_wdata[HALF_W-1:0];
      if (wr_hi) latch_q[CNT_W-1:HALF_W] <= bus_wdata[HALF_W-1:0];
      if (wr_ctrl) begin
        mode_q.pin_en   <= bus_wdata[B_PIN_EN];
        mode_q.toggle   <= bus_wdata[B_TOGGLE];
        mode_q.one_shot <= bus_wdata[B_ONCE];
        mode_q.ext_src  <= bus_wdata[B_EXTSRC];
      end
      run_q  <= run_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq_q  <= flag_d && mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CNT_LO: rdata_q <= cnt_i[HALF_W-1:0];
        A_CNT_HI: rdata_q <= cnt_i[CNT_W-1:HALF_W];
        A_CTRL:   rdata_q <= {3'b000, mode_q.ext_src, mode_q.one_shot,
                              mode_q.toggle, mode_q.pin_en, run_q};
        default:  rdata_q <= {irq_q, 6'b000000, flag_q};
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign mode_o    = mode_q;
  assign run_o     = run_q;
  assign latch_o   = latch_q;
  assign irq_o     = irq_q;

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (uf_i && mode_q.one_shot && !wr_ctrl && !load_now_o) |=> !run_q);

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    uf_i |=> flag_q);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && mask_q));

  assert_oneshot_load_R6: assert property (@(posedge clk) disable iff (rst)
    load_now_o |=> run_q);
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_count_in,
  input  logic              port_data_in,
  input  logic              port_dir_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  mode_t            mode;
  logic             run, started, load_now, ext_rise, tick, uf, tmr_out;
  logic [CNT_W-1:0] cnt, load_val, latch;

  ptimer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_count_in), .rise_o(ext_rise));

  assign tick = run && (mode.ext_src ? ext_rise : 1'b1);

  ptimer_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_i(cnt), .uf_i(uf),
    .bus_rdata(bus_rdata), .mode_o(mode), .run_o(run),
    .started_o(started), .load_now_o(load_now), .load_val_o(load_val),
    .latch_o(latch), .irq_o(irq));

  ptimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .load_now(load_now),
    .load_val(load_val), .latch_val(latch), .cnt_o(cnt), .uf_o(uf));

  ptimer_outgen u_out (
    .clk(clk), .rst(rst), .started(started), .uf(uf),
    .toggle_sel(mode.toggle), .out_o(tmr_out));

  assign pin_out = mode.pin_en ? tmr_out : port_data_in;
  assign pin_oe  = mode.pin_en | port_dir_in;

  assert_pin_forced_R9: assert property (@(posedge clk) disable iff (rst)
    mode.pin_en |-> pin_oe);
endmodule

// File: tb/ptimer_top_bench.sv
module ptimer_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ext_count_in = 1'b0, port_data_in = 1'b0, port_dir_in = 1'b0;
  logic       pin_out, pin_oe, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  logic  rd_v = 1'b0;

  always #2.5 clk = ~clk;

  ptimer_top u_ptimer_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_count_in(ext_count_in), .port_data_in(port_data_in),
    .port_dir_in(port_dir_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data the cycle after each read strobe
  always @(posedge clk) rd_v <= bus_rd;
  always @(negedge clk) begin
    if (rd_v && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, {8'h00, bus_rdata}, {8'h00, it.exp});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sb_q.push_back('{exp, tag});
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi_cnt, first_hi, n;
    idle(3);
    @(negedge clk); rst = 1'b0;
    port_data_in = 1'b1; port_dir_in = 1'b0;

    // R1 reset state
    rd(2'd0, 8'h00, "R1 cnt lo");
    rd(2'd1, 8'h00, "R1 cnt hi");
    rd(2'd2, 8'h00, "R1 ctrl");
    rd(2'd3, 8'h00, "R1 status");
    @(negedge clk);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 pin_out passthrough", {15'd0, pin_out}, 16'd1);
    check("R1 pin_oe passthrough", {15'd0, pin_oe}, 16'd0);

    // R9 pin override with routing on, output low while stopped
    wr(2'd2, 8'h02);
    @(negedge clk);
    check("R9 pin_oe forced", {15'd0, pin_oe}, 16'd1);
    check("R9 pin_out timer", {15'd0, pin_out}, 16'd0);
    wr(2'd2, 8'h00);
    port_dir_in = 1'b1; port_data_in = 1'b0;
    @(negedge clk);
    check("R9 pin_oe dir", {15'd0, pin_oe}, 16'd1);
    check("R9 pin_out data", {15'd0, pin_out}, 16'd0);

    // R2 latch writes leave counter untouched in continuous mode
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h07);
    rd(2'd0, 8'h00, "R2 cnt lo after latch write");
    rd(2'd1, 8'h00, "R2 cnt hi after latch write");

    // R6 one-shot high write loads and starts; R3 stop freezes
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);   // loads 0x1234, running
    wr(2'd2, 8'h08);   // one tick then stopped -> 0x1233
    rd(2'd0, 8'h33, "R6 loaded lo");
    rd(2'd1, 8'h12, "R6 loaded hi");
    idle(10);
    rd(2'd0, 8'h33, "R3 frozen lo");

    // R5/R7 one-shot pulse
    wr(2'd2, 8'h0A);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h00);
    hi_cnt = 0; first_hi = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (pin_out) begin
        hi_cnt++;
        if (first_hi == 0) first_hi = i;
      end
    end
    check("R7 pulse width", hi_cnt[15:0], 16'd1);
    check("R7 pulse position", first_hi[15:0], 16'd5);
    rd(2'd2, 8'h0A, "R5 run cleared");
    rd(2'd0, 8'h03, "R5 reloaded");
    rd(2'd3, 8'h01, "R10 flag set");
    rd(2'd3, 8'h00, "R10 flag cleared by read");

    // R11 interrupt with mask
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    idle(8);
    check("R11 irq high", {15'd0, irq}, 16'd1);
    rd(2'd3, 8'h81, "R11 status irq bit");
    check("R11 irq low after read", {15'd0, irq}, 16'd0);
    wr(2'd3, 8'h00);

    // R12 external rising edges only
    wr(2'd2, 8'h18);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    idle(10);
    rd(2'd0, 8'h02, "R12 no ext edge no count");
    ext_count_in = 1'b1; idle(8);
    ext_count_in = 1'b0; idle(8);
    rd(2'd0, 8'h01, "R12 one edge one count");
    rd(2'd1, 8'h00, "R12 hi byte");

    // R8 / R4 continuous toggle, period latch+1
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h07);
    @(negedge clk);
    check("R8 toggle high on start", {15'd0, pin_out}, 16'd1);
    while (pin_out !== 1'b0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (pin_out === 1'b0 && n < 50);
    check("R4 low phase = latch+1", n[15:0], 16'd5);
    n = 0;
    do begin @(negedge clk); n++; end while (pin_out === 1'b1 && n < 50);
    check("R8 high phase = latch+1", n[15:0], 16'd5);

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule